// File: doc/BRIEF.md
# Coherent Multiprocessor L1 Tag Model

This block is a functional model of the private first-level caches of a shared-memory multiprocessor. It keeps only tags and coherence state, never data. Each request names a CPU, says whether it is a load or a store, and gives a byte address. The block sorts the reference into one of five outcomes: read hit, write hit, read miss, plain write miss, or upgrade. It then updates the requesting cache and snoops the same set in every other CPU's cache. A statistics unit counts the outcomes from a response strobe that carries a classification code and three flags.

Coherence follows an MSI-like scheme with two bits per way: valid and modified. A read miss always brings the line in read-only, even when no other cache holds it. The first store to that line is therefore always counted as an upgrade.

The controller is a four-state machine:
- **CLEAR** is entered from reset. It sweeps one set index per cycle and invalidates that set in every cache. After the last set it moves to IDLE.
- **IDLE** raises `req_ready`. An accepted request latches the reference and moves to LOOKUP.
- **LOOKUP** matches tags in all caches, classifies the reference, writes every state change and registers the response. It always moves to RESPOND.
- **RESPOND** pulses `resp_valid` for one cycle and returns to IDLE.

Top module: `l1_coherent_tags`

## Requirements
- R1: The address splits into offset bits [5:0], set index bits [14:6] and tag bits [31:15]. Any two addresses that share tag and index refer to the same line (for example, 0x103C0 has tag 0x2 and index 0xF).
- R2: A load that finds no valid matching way is a read miss: code 2, `resp_read`=1, `resp_hit`=0. The line is filled read-only.
- R3: A load that finds a valid matching way is a read hit: code 6, `resp_hit`=1, `resp_read`=1.
- R4: A store to a line the requester holds read-only is an upgrade: code 5, `resp_upgrade`=1, `resp_hit`=0. The line becomes writable, so the next store to it is a write hit.
- R5: A store to a line the requester holds writable is a write hit: code 4, `resp_hit`=1, `resp_read`=0, `resp_upgrade`=0.
- R6: A store to a line absent from the requester's cache is a plain write miss: code 0, all flags 0. The line is allocated writable and every peer copy is invalidated.
- R7: An upgrade invalidates all peer copies of the line, so a later load by a peer misses.
- R8: A read miss downgrades a peer's writable copy to read-only. The peer's copy stays valid, and its next store is an upgrade.
- R9: A fill uses an invalid way if one exists. Otherwise it evicts the least recently used way, where every hit and every fill counts as a use.
- R10: `req_ready` is low from the cycle after an accepted request until the response has been given. `resp_valid` rises exactly two cycles after the accepting edge and lasts one cycle.
- R11: During reset `resp_valid` and `req_ready` are 0. After reset is released, `req_ready` stays low for SETS cycles while every line is invalidated. After that, no earlier line hits.
- R12: A reference to one set does not change the state of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_cpu | input | CPU_W | Requesting CPU |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Reference hit |
| resp_read | output | 1 | Reference was a load |
| resp_upgrade | output | 1 | Store found a read-only copy |
| resp_code | output | 3 | Classification: 0 write miss, 2 read miss, 4 write hit, 5 upgrade, 6 read hit |

## Verification
The bench replays the two-CPU sharing sequence on one set. If the downgrade were missing, a later store by the original owner would show up as a write hit instead of an upgrade. If the LRU bit were not updated on a hit, the wrong tag would be evicted and a following reference would hit where it should miss. Invalidation is probed by loads from the peer after an upgrade and after a plain write miss: a model that did not snoop would report read hits there. Reset is checked twice, including a reset in the middle of a run: a sweep that left stale valid bits would turn the first store after the sweep into a hit or an upgrade instead of a plain write miss.

// File: rtl/l1c_pkg.sv
package l1c_pkg;

    typedef enum logic [2:0] {
        CLS_WR_MISS = 3'd0,
        CLS_RD_MISS = 3'd2,
        CLS_WR_HIT  = 3'd4,
        CLS_UPGRADE = 3'd5,
        CLS_RD_HIT  = 3'd6
    } cls_e;

    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_LOOKUP,
        ST_RESPOND
    } fsm_e;

endpackage

// File: rtl/l1c_way_match.sv
module l1c_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 17,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAYS-1:0]  mod_i,
    input  logic [TAG_W-1:0] tags_i [WAYS],
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_o,
    output logic [WAY_W-1:0] way_o,
    output logic             mod_o
);
    always_comb begin
        hit_o = 1'b0;
        way_o = '0;
        mod_o = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_i[w] && (tags_i[w] == tag_i) && !hit_o) begin
                hit_o = 1'b1;
                way_o = WAY_W'(w);
                mod_o = mod_i[w];
            end
        end
    end
endmodule

// File: rtl/l1c_victim.sv
module l1c_victim #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] lru_i,
    output logic [WAY_W-1:0] victim_o
);
    logic found;

    always_comb begin
        victim_o = lru_i;
        found    = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_i[w] && !found) begin
                victim_o = WAY_W'(w);
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/l1c_classify.sv
module l1c_classify
    import l1c_pkg::*;
(
    input  logic wr_i,
    input  logic hit_i,
    input  logic mod_i,
    output cls_e cls_o,
    output logic hit_o,
    output logic read_o,
    output logic upgrade_o
);
    always_comb begin
        if (!wr_i)
            cls_o = hit_i ? CLS_RD_HIT : CLS_RD_MISS;
        else if (!hit_i)
            cls_o = CLS_WR_MISS;
        else
            cls_o = mod_i ? CLS_WR_HIT : CLS_UPGRADE;
        hit_o     = (cls_o == CLS_RD_HIT) || (cls_o == CLS_WR_HIT);
        read_o    = !wr_i;
        upgrade_o = (cls_o == CLS_UPGRADE);
    end
endmodule

// File: rtl/l1_coherent_tags.sv
module l1_coherent_tags
    import l1c_pkg::*;
#(
    parameter int NCPU       = 4,
    parameter int SETS       = 512,
    parameter int WAYS       = 2,
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 32,
    localparam int CPU_W     = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_read,
    output logic              resp_upgrade,
    output logic [2:0]        resp_code
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    // Tag store: per CPU, per set, per way
    logic [TAG_W-1:0] tag_q [NCPU][SETS][WAYS];
    logic [WAYS-1:0]  vld_q [NCPU][SETS];
    logic [WAYS-1:0]  mod_q [NCPU][SETS];
    logic [WAY_W-1:0] lru_q [NCPU][SETS];

    fsm_e             state, state_nx;
    logic [IDX_W-1:0] clr_idx;

    logic [CPU_W-1:0] cpu_r;
    logic             wr_r;
    logic [TAG_W-1:0] tag_r;
    logic [IDX_W-1:0] idx_r;

    logic             unused_offset_bits;
    assign unused_offset_bits = ^req_addr[OFF_W-1:0];

    logic [NCPU-1:0]  hit_v;
    logic [NCPU-1:0]  hmod_v;
    logic [WAY_W-1:0] hway_v [NCPU];

    for (genvar k = 0; k < NCPU; k++) begin : g_snoop
        l1c_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
            .valid_i (vld_q[k][idx_r]),
            .mod_i   (mod_q[k][idx_r]),
            .tags_i  (tag_q[k][idx_r]),
            .tag_i   (tag_r),
            .hit_o   (hit_v[k]),
            .way_o   (hway_v[k]),
            .mod_o   (hmod_v[k])
        );
    end

    logic [WAY_W-1:0] victim;
    l1c_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid_i  (vld_q[cpu_r][idx_r]),
        .lru_i    (lru_q[cpu_r][idx_r]),
        .victim_o (victim)
    );

    cls_e cls;
    logic cls_hit, cls_read, cls_upg;
    l1c_classify u_cls (
        .wr_i      (wr_r),
        .hit_i     (hit_v[cpu_r]),
        .mod_i     (hmod_v[cpu_r]),
        .cls_o     (cls),
        .hit_o     (cls_hit),
        .read_o    (cls_read),
        .upgrade_o (cls_upg)
    );

    function automatic logic [WAY_W-1:0] after_way(input logic [WAY_W-1:0] w);
        return (int'(w) == WAYS - 1) ? '0 : w + 1'b1;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            clr_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_CLEAR)
                clr_idx <= clr_idx + 1'b1;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR:   if (int'(clr_idx) == SETS - 1) state_nx = ST_IDLE;
            ST_IDLE:    if (req_valid) state_nx = ST_LOOKUP;
            ST_LOOKUP:  state_nx = ST_RESPOND;
            ST_RESPOND: state_nx = ST_IDLE;
            default:    state_nx = ST_CLEAR;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_ready  = (state == ST_IDLE);
        resp_valid = (state == ST_RESPOND);
    end

    // Request capture and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_r        <= '0;
            wr_r         <= 1'b0;
            tag_r        <= '0;
            idx_r        <= '0;
            resp_hit     <= 1'b0;
            resp_read    <= 1'b0;
            resp_upgrade <= 1'b0;
            resp_code    <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            cpu_r <= req_cpu;
            wr_r  <= req_write;
            tag_r <= req_addr[ADDR_W-1 -: TAG_W];
            idx_r <= req_addr[OFF_W +: IDX_W];
        end else if (state == ST_LOOKUP) begin
            resp_hit     <= cls_hit;
            resp_read    <= cls_read;
            resp_upgrade <= cls_upg;
            resp_code    <= cls;
        end
    end

    // Tag store update: fill or touch the requester, snoop the peers
    always_ff @(posedge clk) begin
        if (state == ST_CLEAR) begin
            for (int k = 0; k < NCPU; k++) begin
                vld_q[k][clr_idx] <= '0;
                mod_q[k][clr_idx] <= '0;
                lru_q[k][clr_idx] <= '0;
            end
        end else if (state == ST_LOOKUP) begin
            for (int k = 0; k < NCPU; k++) begin
                if (CPU_W'(k) == cpu_r) begin
                    if (hit_v[k]) begin
                        lru_q[k][idx_r] <= after_way(hway_v[k]);
                        if (wr_r) mod_q[k][idx_r][hway_v[k]] <= 1'b1;
                    end else begin
                        tag_q[k][idx_r][victim] <= tag_r;
                        vld_q[k][idx_r][victim] <= 1'b1;
                        mod_q[k][idx_r][victim] <= wr_r;
                        lru_q[k][idx_r]         <= after_way(victim);
                    end
                end else if (hit_v[k]) begin
                    mod_q[k][idx_r][hway_v[k]] <= 1'b0;
                    if (wr_r) vld_q[k][idx_r][hway_v[k]] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/l1_coherent_tags_chk.sv
module l1_coherent_tags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       resp_valid,
    input logic       resp_hit,
    input logic       resp_read,
    input logic       resp_upgrade,
    input logic [2:0] resp_code
);
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_resp_two_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_ready, 2) |-> resp_valid);

    p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_no_ready_in_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_code == 3'd0 || resp_code == 3'd2 || resp_code == 3'd4 ||
                        resp_code == 3'd5 || resp_code == 3'd6));

    p_upgrade_is_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_upgrade) |-> (!resp_hit && !resp_read && resp_code == 3'd5));

    p_write_hit_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 3'd4) |-> (resp_hit && !resp_read));

    p_write_miss_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 3'd0) |-> (!resp_hit && !resp_read && !resp_upgrade));
endmodule

bind l1_coherent_tags l1_coherent_tags_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .resp_read    (resp_read),
    .resp_upgrade (resp_upgrade),
    .resp_code    (resp_code)
);

// File: tb/l1_coherent_tags_test.sv
module l1_coherent_tags_test;
    localparam int SETS = 512;
    localparam int NV   = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_cpu = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        resp_valid, resp_hit, resp_read, resp_upgrade;
    logic [2:0]  resp_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    l1_coherent_tags uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cpu(req_cpu), .req_write(req_write), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_read(resp_read),
        .resp_upgrade(resp_upgrade), .resp_code(resp_code)
    );

    // {cpu[1:0], write, addr[31:0], expected code[2:0]}
    localparam logic [37:0] VEC [NV] = '{
        {2'd1, 1'b0, 32'h000103C0, 3'd2},  // R1 tag 2 idx F, first fill
        {2'd1, 1'b1, 32'h000103C2, 3'd5},  // same line, read-only -> upgrade
        {2'd1, 1'b0, 32'h000103C4, 3'd6},
        {2'd2, 1'b0, 32'h000103C6, 3'd2},  // R8 downgrades cpu1
        {2'd2, 1'b1, 32'h000103C8, 3'd5},  // R7 invalidates cpu1
        {2'd2, 1'b0, 32'h000183C8, 3'd2},  // R9 second way
        {2'd2, 1'b0, 32'h000103C8, 3'd6},  // touch tag 2
        {2'd2, 1'b0, 32'h000283C8, 3'd2},  // R9 evicts tag 3
        {2'd2, 1'b0, 32'h000183C8, 3'd2},  // R9 tag 3 misses again
        {2'd1, 1'b0, 32'h000103C0, 3'd2},  // R7 cpu1 copy was invalidated
        {2'd1, 1'b1, 32'h000103C0, 3'd5},
        {2'd1, 1'b1, 32'h000103C0, 3'd4},  // R4 upgrade made it writable
        {2'd3, 1'b1, 32'h00040000, 3'd0},
        {2'd0, 1'b0, 32'h00040000, 3'd2},  // R8 downgrades cpu3
        {2'd3, 1'b1, 32'h00040000, 3'd5},  // R8 cpu3 now upgrades
        {2'd0, 1'b0, 32'h00040010, 3'd2},  // R7 cpu0 invalidated
        {2'd3, 1'b0, 32'h00040000, 3'd6},  // R8 downgraded copy still valid
        {2'd0, 1'b1, 32'h00040000, 3'd5},
        {2'd3, 1'b0, 32'h00040000, 3'd2},  // R7
        {2'd3, 1'b0, 32'h00040040, 3'd2},  // R12 set 1 untouched so far
        {2'd1, 1'b0, 32'h00050000, 3'd2},
        {2'd2, 1'b1, 32'h00050000, 3'd0},  // R6 plain write miss
        {2'd1, 1'b0, 32'h00050000, 3'd2}   // R6 peer copy invalidated
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string code_req(input logic [2:0] c);
        case (c)
            3'd2:    return "R2";
            3'd6:    return "R3";
            3'd5:    return "R4";
            3'd4:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic do_ref(input logic [1:0] cpu, input logic wr, input logic [31:0] addr,
                          input logic [2:0] exp, input string req);
        int n;
        bit eh, er, eu;
        eh = (exp == 3'd4) || (exp == 3'd6);
        er = !wr;
        eu = (exp == 3'd5);
        @(negedge clk);
        req_cpu = cpu; req_write = wr; req_addr = addr; req_valid = 1'b1;
        n = 0;
        while (!req_ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", "ready after accept", int'(req_ready), 0);
        chk(resp_valid == 1'b0, "R10", "resp one cycle after accept", int'(resp_valid), 0);
        @(negedge clk);
        chk(resp_valid == 1'b1, "R10", "resp two cycles after accept", int'(resp_valid), 1);
        chk(resp_code == exp, req, "code", int'(resp_code), int'(exp));
        chk(resp_hit == eh, req, "hit flag", int'(resp_hit), int'(eh));
        chk(resp_read == er, req, "read flag", int'(resp_read), int'(er));
        chk(resp_upgrade == eu, req, "upgrade flag", int'(resp_upgrade), int'(eu));
        @(negedge clk);
        chk(resp_valid == 1'b0, "R10", "resp single pulse", int'(resp_valid), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(resp_valid == 1'b0, "R11", "resp_valid in reset", int'(resp_valid), 0);
        chk(req_ready == 1'b0, "R11", "req_ready in reset", int'(req_ready), 0);
        rst_n = 1'b1;
        repeat (SETS - 1) @(negedge clk);
        chk(req_ready == 1'b0, "R11", "ready low during sweep", int'(req_ready), 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready after sweep", int'(req_ready), 1);
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) begin
            do_ref(VEC[i][37:36], VEC[i][35], VEC[i][34:3], VEC[i][2:0],
                   code_req(VEC[i][2:0]));
        end
        // R12: set 0x10 is untouched by all references in set 0xF
        do_ref(2'd2, 1'b1, 32'h00010400, 3'd0, "R12");
        // R1: different offsets of one line share the entry
        do_ref(2'd2, 1'b1, 32'h0001043F, 3'd4, "R1");
        // R11: reset mid-run wipes every line, store is a plain miss
        do_reset();
        do_ref(2'd1, 1'b1, 32'h000103C0, 3'd0, "R11");
        do_ref(2'd2, 1'b0, 32'h00010400, 3'd2, "R11");
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule